// File: doc/BRIEF.md
# DMA Single-Read Sequencer for Bank-Active SDRAM

This block runs one DMA single-transfer read against a synchronous DRAM whose bank is kept open between accesses, and it drives the DMA acknowledge strobe (active high) around that read. It remembers which row is currently open. When a request arrives it compares the request's row against that open row. On a match it issues the column read at once. Otherwise it closes the bank, waits, opens the new row, waits again and then issues the read.

The DRAM can only read in bursts, so one wanted beat comes back with several trailing beats that carry no useful data. The block lets those trailing beats run out and keeps the acknowledge high through them. It then holds the acknowledge until the DMA engine reports that the destination write address phase has started. The acknowledge is released one cycle after that report.

The row is the address above a parameterised column field. CAS latency, burst length and the bank open/close gap are parameters.

Top module: `dma_sdram_rd_ack`

## Requirements
- R1: After reset the block is idle with busy, acknowledge, all commands and data-valid low, and no row is considered open, so the first request always takes the miss sequence.
- R2: A request accepted on edge 0 whose row equals the open row gives a read command in cycle 1, and no precharge or activate.
- R3: A request whose row differs from the open row gives precharge in cycle 1, then GAP_CYC idle cycles, then activate, then GAP_CYC idle cycles, then the read command.
- R4: During activate the address output carries the row bits (address bits above COL_W, zero-extended). During the read command it carries the column bits (the low COL_W bits, zero-extended). Otherwise it is zero. The activated row becomes the open row.
- R5: Data-valid is high for exactly one cycle, CAS_LAT cycles after the read command. The following BURST_LEN-1 beat cycles are invalid beats.
- R6: The acknowledge is high continuously from cycle 1 after acceptance, through all commands, waits and all BURST_LEN beats.
- R7: After the last beat the acknowledge stays high until the write-phase input is sampled high, and it falls in the following cycle. A write-phase input that is already high during the beats releases the acknowledge in the cycle after the first hold cycle.
- R8: Busy equals the acknowledge. A request while busy is ignored: it changes neither the running sequence nor the open row.
- R9: At most one of precharge, activate and read is high in any cycle, and a command is only issued while the acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Single-read request, sampled when idle |
| req_addr_i | input | ADDR_W | Source address of the request |
| wr_phase_i | input | 1 | Destination write address phase is starting |
| busy_o | output | 1 | Transfer in progress |
| dack_o | output | 1 | DMA acknowledge, active high |
| cmd_pre_o | output | 1 | Precharge command strobe |
| cmd_act_o | output | 1 | Activate (row open) command strobe |
| cmd_rd_o | output | 1 | Read command strobe |
| sd_addr_o | output | ADDR_W | Row or column address for the current command |
| data_valid_o | output | 1 | The current read beat carries the wanted data |

## Verification
The assertions check properties that hold on every cycle. At most one command is issued at a time. Commands and data-valid appear only under the acknowledge. Busy tracks the acknowledge. Activate never directly follows precharge. The acknowledge only falls after the write-phase input was high. They cannot show the exact cycle each command appears, the hit or miss choice, the row and column values on the address output, or that a request made while busy leaves the open row untouched. Those come only from the bench's directed scenarios, which compare every cycle of each transfer against a cycle count derived from the parameters.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_PWAIT,
      ST_ACT,
      ST_AWAIT,
      ST_RD,
      ST_CASW,
      ST_BEAT,
      ST_HOLD
   } dsr_state_e;
endpackage

// File: rtl/dsr_row_track.sv
module dsr_row_track #(
   parameter int ADDR_W = 16,
   parameter int COL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cmp_addr_i,
   input  logic [ADDR_W-1:0] upd_addr_i,
   input  logic              upd_i,
   output logic              hit_o
);
   localparam int ROW_W = ADDR_W - COL_W;

   logic [ROW_W-1:0] open_row_q;
   logic             open_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_row_q <= '0;
         open_vld_q <= 1'b0;
      end else if (upd_i) begin
         open_row_q <= upd_addr_i[ADDR_W-1:COL_W];
         open_vld_q <= 1'b1;
      end
   end

   assign hit_o = open_vld_q && (cmp_addr_i[ADDR_W-1:COL_W] == open_row_q);
endmodule

// File: rtl/dsr_timer.sv
module dsr_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dma_sdram_rd_ack.sv
module dma_sdram_rd_ack #(
   parameter int ADDR_W    = 16,
   parameter int COL_W     = 8,
   parameter int CAS_LAT   = 2,
   parameter int BURST_LEN = 4,
   parameter int GAP_CYC   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic              wr_phase_i,
   output logic              busy_o,
   output logic              dack_o,
   output logic              cmd_pre_o,
   output logic              cmd_act_o,
   output logic              cmd_rd_o,
   output logic [ADDR_W-1:0] sd_addr_o,
   output logic              data_valid_o
);
   import dsr_pkg::*;

   localparam int ROW_W  = ADDR_W - COL_W;
   localparam int V_GAP  = GAP_CYC - 1;
   localparam int V_CAS  = CAS_LAT - 2;
   localparam int V_BST  = BURST_LEN - 1;
   localparam int V_M1   = (V_GAP > V_CAS) ? V_GAP : V_CAS;
   localparam int V_MAX  = (V_M1 > V_BST) ? V_M1 : V_BST;
   localparam int CNT_W  = $clog2(V_MAX + 1) < 1 ? 1 : $clog2(V_MAX + 1);

   generate
      if (COL_W < 1 || ROW_W < 1) begin : g_bad_split
         $error("dma_sdram_rd_ack: COL_W must leave at least one row bit");
      end
      if (CAS_LAT < 2) begin : g_bad_cas
         $error("dma_sdram_rd_ack: CAS_LAT must be at least 2");
      end
      if (BURST_LEN < 1) begin : g_bad_burst
         $error("dma_sdram_rd_ack: BURST_LEN must be at least 1");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("dma_sdram_rd_ack: GAP_CYC must be at least 1");
      end
   endgenerate

   dsr_state_e        state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic              row_hit;
   logic              tmr_zero;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              first_beat_q;

   dsr_row_track #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_rows (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmp_addr_i (req_addr_i),
      .upd_addr_i (addr_q),
      .upd_i      (state_q == ST_ACT),
      .hit_o      (row_hit)
   );

   dsr_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE:  if (req_i) state_d = row_hit ? ST_RD : ST_PRE;
         ST_PRE: begin
            state_d  = ST_PWAIT;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(V_GAP);
         end
         ST_PWAIT: if (tmr_zero) state_d = ST_ACT;
         ST_ACT: begin
            state_d  = ST_AWAIT;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(V_GAP);
         end
         ST_AWAIT: if (tmr_zero) state_d = ST_RD;
         ST_RD: begin
            state_d  = ST_CASW;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(V_CAS);
         end
         ST_CASW: begin
            if (tmr_zero) begin
               state_d  = ST_BEAT;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(V_BST);
            end
         end
         ST_BEAT:  if (tmr_zero) state_d = ST_HOLD;
         ST_HOLD:  if (wr_phase_i) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         addr_q       <= '0;
         first_beat_q <= 1'b0;
      end else begin
         state_q      <= state_d;
         first_beat_q <= (state_q == ST_CASW) && tmr_zero;
         if (state_q == ST_IDLE && req_i) addr_q <= req_addr_i;
      end
   end

   always_comb begin
      sd_addr_o = '0;
      if (state_q == ST_ACT)
         sd_addr_o = ADDR_W'(addr_q[ADDR_W-1:COL_W]);
      else if (state_q == ST_RD)
         sd_addr_o = ADDR_W'(addr_q[COL_W-1:0]);
   end

   assign dack_o       = (state_q != ST_IDLE);
   assign busy_o       = (state_q != ST_IDLE);
   assign cmd_pre_o    = (state_q == ST_PRE);
   assign cmd_act_o    = (state_q == ST_ACT);
   assign cmd_rd_o     = (state_q == ST_RD);
   assign data_valid_o = (state_q == ST_BEAT) && first_beat_q;
endmodule

// File: rtl/dma_sdram_rd_ack_chk.sv
module dma_sdram_rd_ack_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_phase_i,
   input logic busy_o,
   input logic dack_o,
   input logic cmd_pre_o,
   input logic cmd_act_o,
   input logic cmd_rd_o,
   input logic data_valid_o
);
   a_r9_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_pre_o, cmd_act_o, cmd_rd_o}));

   a_r9_cmd_under_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_pre_o || cmd_act_o || cmd_rd_o) |-> dack_o);

   a_r5_valid_under_ack: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |-> dack_o);

   a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |=> !data_valid_o);

   a_r8_busy_tracks_ack: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o == dack_o);

   a_r3_gap_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pre_o |=> !cmd_act_o);

   a_r7_release_on_wr: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dack_o) |-> $past(wr_phase_i));
endmodule

bind dma_sdram_rd_ack dma_sdram_rd_ack_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_phase_i   (wr_phase_i),
   .busy_o       (busy_o),
   .dack_o       (dack_o),
   .cmd_pre_o    (cmd_pre_o),
   .cmd_act_o    (cmd_act_o),
   .cmd_rd_o     (cmd_rd_o),
   .data_valid_o (data_valid_o)
);

// File: tb/dma_sdram_rd_ack_tb.sv
module dma_sdram_rd_ack_tb;
   localparam int ADDR_W = 16;
   localparam int COL_W  = 8;
   localparam int CAS    = 2;
   localparam int BL     = 4;
   localparam int GAP    = 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              wr = 1'b0;
   logic              busy, dack, pre, act, rd, dv;
   logic [ADDR_W-1:0] sda;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   dma_sdram_rd_ack #(.ADDR_W(ADDR_W), .COL_W(COL_W), .CAS_LAT(CAS),
                      .BURST_LEN(BL), .GAP_CYC(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(req_addr),
      .wr_phase_i(wr), .busy_o(busy), .dack_o(dack), .cmd_pre_o(pre),
      .cmd_act_o(act), .cmd_rd_o(rd), .sd_addr_o(sda), .data_valid_o(dv));

   task automatic chk(input bit ok, input string tag, input int got, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
      end
   endtask

   // One transfer. hit: expected row match. wr_at: cycle the write phase input rises.
   // poke: a second request is raised while busy (must be ignored).
   task automatic run_xfer(input logic [ADDR_W-1:0] addr, input bit hit,
                           input int wr_at, input bit poke, input string tag);
      int rdk, hold, last_ack;
      rdk      = hit ? 1 : 3 + 2 * GAP;
      hold     = rdk + CAS + BL;
      last_ack = (wr_at > hold) ? wr_at : hold;
      @(negedge clk);
      req = 1'b1; req_addr = addr;
      for (int k = 1; k <= last_ack + 1; k++) begin
         @(negedge clk);
         begin
            bit e_ack, e_pre, e_act, e_rd, e_dv;
            e_ack = (k <= last_ack);
            e_pre = !hit && (k == 1);
            e_act = !hit && (k == 2 + GAP);
            e_rd  = (k == rdk);
            e_dv  = (k == rdk + CAS);
            // R6 R7 R8: acknowledge span and busy
            chk(dack == e_ack && busy == e_ack, {tag, " R6/R7/R8 ack"}, {busy, dack}, {e_ack, e_ack});
            // R2 R3 R9: command sequence
            chk({pre, act, rd} == {e_pre, e_act, e_rd}, {tag, " R2/R3 cmd"}, {pre, act, rd}, {e_pre, e_act, e_rd});
            // R5: single valid beat
            chk(dv == e_dv, {tag, " R5 valid"}, dv, e_dv);
            // R4: address content
            if (e_act) chk(sda == ADDR_W'(addr[ADDR_W-1:COL_W]), {tag, " R4 row"}, sda, addr[ADDR_W-1:COL_W]);
            if (e_rd)  chk(sda == ADDR_W'(addr[COL_W-1:0]), {tag, " R4 col"}, sda, addr[COL_W-1:0]);
         end
         req = poke && (k == 2);
         if (poke && k == 2) req_addr = addr ^ 16'hA500;
         if (k == 1 && !poke) req = 1'b0;
         wr = (k >= wr_at) && (k <= last_ack);
      end
      req = 1'b0; wr = 1'b0;
   endtask

   task automatic check_reset();
      chk({busy, dack, pre, act, rd, dv} == 6'b0 && sda == '0, "R1 reset outputs",
          {busy, dack, pre, act, rd, dv}, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_reset();
      rst_n = 1'b1;
      @(negedge clk);
      check_reset();
      run_xfer(16'h0512, 1'b0, 12, 1'b0, "R1 first miss");
      run_xfer(16'h0534, 1'b1, 5, 1'b0, "R2 hit");
      run_xfer(16'h0977, 1'b0, 3, 1'b0, "R3 miss new row");
      run_xfer(16'h0901, 1'b1, 20, 1'b0, "R7 late write");
      run_xfer(16'h0902, 1'b1, 1, 1'b0, "R7 early write");
      run_xfer(16'h0903, 1'b1, 8, 1'b1, "R8 poke busy");
      run_xfer(16'h0904, 1'b1, 7, 1'b0, "R8 row kept");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); check_reset(); rst_n = 1'b1;
      run_xfer(16'h0905, 1'b0, 9, 1'b0, "R1 miss after reset");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule